// File: doc/BRIEF.md
# 100BASE-X Transmit Code-Group Encoder

This block sits between the MAC side of a media independent transmit interface and a later serializer. Each nibble clock it samples a transmit enable, a transmit error flag and a 4-bit data nibble. One cycle later it presents a registered 5-bit code group. The serializer consumes that group in parallel. Scrambling and line coding happen downstream.

Between frames the output is the IDLE group. When the enable rises, the block takes it to arrive with the first preamble nibble. It replaces the first two preamble nibbles with the J/K start-of-stream pair and maps every following nibble through the 4B/5B table. While the error flag is high inside a frame, it sends the H group in place of the data. The enable falls after the last nibble. The block then appends the T/R end-of-stream pair and returns to IDLE. A transmit-active flag marks every cycle from J to R, so collision detection can use it.

Top module: `mii_tx_4b5b`

## Requirements
- R1: After reset, and until a frame starts, `code_grp` is IDLE (5'b11111) and `tx_active` is 0.
- R2: If `tx_en` is sampled high while no stream is in progress, the next code group is J (5'b11000). That nibble is discarded.
- R3: The group after J is always K (5'b10001), whatever `tx_en`, `tx_er` and `txd` hold on that cycle. This holds even for a frame one nibble long.
- R4: Each later nibble sampled with `tx_en` high and `tx_er` low is sent one cycle later as its 4B/5B group. The 16 groups for nibble values 0 to 15 are: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: A nibble sampled in the data phase with both `tx_en` and `tx_er` high is sent as H (5'b00100).
- R6: The first low `tx_en` after the data phase produces T (5'b01101), then R (5'b00111). If the frame ended on its J nibble, T follows K.
- R7: While no stream is in progress and `tx_en` is low, the output stays IDLE whatever `tx_er` and `txd` are.
- R8: If `tx_en` rises while T or R is being produced, the tail still completes. J comes on the cycle right after R.
- R9: `tx_active` is 1 exactly while `code_grp` is J, K, a data group, H, T or R. It is 0 while `code_grp` is IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| tx_er | input | 1 | Transmit error from the MAC |
| txd | input | 4 | Transmit data nibble |
| code_grp | output | 5 | Registered 5-bit code group |
| tx_active | output | 1 | High from J through R |

## Verification
The bench sweeps frame lengths from one nibble upward, with idle gaps of one to three cycles. A design that dropped the tail when the enable came back after one idle cycle would send J straight after T. A design that started its count in the wrong place would leak a data group where K belongs. The bench drives the error flag during idle gaps, and a block that honoured it there would put H on an idle line. It also drives the error flag on selected data nibbles and in the delimiter slots. A wrong design would either miss the H or corrupt J/K. Every nibble value passes through the data path, so a single wrong table entry shows up as one bad group.

// File: rtl/mii_tx_4b5b.sv
module mii_tx_4b5b (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       tx_er,
  input  logic [3:0] txd,
  output logic [4:0] code_grp,
  output logic       tx_active
);
  localparam logic [4:0] C_IDLE = 5'b11111;
  localparam logic [4:0] C_J    = 5'b11000;
  localparam logic [4:0] C_K    = 5'b10001;
  localparam logic [4:0] C_T    = 5'b01101;
  localparam logic [4:0] C_R    = 5'b00111;
  localparam logic [4:0] C_H    = 5'b00100;

  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_J    = 3'd1;
  localparam logic [2:0] S_DATA = 3'd2;
  localparam logic [2:0] S_KEND = 3'd3;
  localparam logic [2:0] S_T    = 3'd4;
  localparam logic [2:0] S_R    = 3'd5;

  logic [2:0] st, st_nx;
  logic [4:0] grp_nx, dgrp;
  logic       act_nx;

  always_comb begin
    case (txd)
      4'h0: dgrp = 5'b11110;
      4'h1: dgrp = 5'b01001;
      4'h2: dgrp = 5'b10100;
      4'h3: dgrp = 5'b10101;
      4'h4: dgrp = 5'b01010;
      4'h5: dgrp = 5'b01011;
      4'h6: dgrp = 5'b01110;
      4'h7: dgrp = 5'b01111;
      4'h8: dgrp = 5'b10010;
      4'h9: dgrp = 5'b10011;
      4'hA: dgrp = 5'b10110;
      4'hB: dgrp = 5'b10111;
      4'hC: dgrp = 5'b11010;
      4'hD: dgrp = 5'b11011;
      4'hE: dgrp = 5'b11100;
      default: dgrp = 5'b11101;
    endcase
  end

  always_comb begin
    st_nx  = S_IDLE;
    grp_nx = C_IDLE;
    act_nx = 1'b0;
    case (st)
      S_IDLE, S_R: if (tx_en) begin
        st_nx = S_J; grp_nx = C_J; act_nx = 1'b1;
      end
      S_J: begin
        st_nx = tx_en ? S_DATA : S_KEND; grp_nx = C_K; act_nx = 1'b1;
      end
      S_DATA: begin
        act_nx = 1'b1;
        if (tx_en) begin
          st_nx = S_DATA; grp_nx = tx_er ? C_H : dgrp;
        end else begin
          st_nx = S_T; grp_nx = C_T;
        end
      end
      S_KEND: begin
        st_nx = S_T; grp_nx = C_T; act_nx = 1'b1;
      end
      S_T: begin
        st_nx = S_R; grp_nx = C_R; act_nx = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      code_grp  <= C_IDLE;
      tx_active <= 1'b0;
    end else begin
      st        <= st_nx;
      code_grp  <= grp_nx;
      tx_active <= act_nx;
    end
  end
endmodule

module mii_tx_4b5b_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic       tx_er,
  input logic [2:0] st,
  input logic [4:0] code_grp,
  input logic       tx_active
);
  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && tx_en) |=> code_grp == 5'b11000);
  a_r3_k_after_j: assert property (@(posedge clk) disable iff (!rst_n)
    (code_grp == 5'b11000) |=> code_grp == 5'b10001);
  a_r5_err_h: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd2 && tx_en && tx_er) |=> code_grp == 5'b00100);
  a_r6_t_then_r: assert property (@(posedge clk) disable iff (!rst_n)
    (code_grp == 5'b01101) |=> code_grp == 5'b00111);
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && !tx_en) |=> code_grp == 5'b11111);
  a_r9_active: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active == (code_grp != 5'b11111));
endmodule

bind mii_tx_4b5b mii_tx_4b5b_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er),
  .st(st), .code_grp(code_grp), .tx_active(tx_active)
);

// File: tb/tb_mii_tx_4b5b.sv
module tb_mii_tx_4b5b;
  logic clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0, tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic [4:0] code_grp;
  logic       tx_active;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mii_tx_4b5b dut (.clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er),
                   .txd(txd), .code_grp(code_grp), .tx_active(tx_active));

  // 4B/5B groups packed: entry n at bits [5n+4:5n]
  localparam logic [79:0] TBL = {5'b11101,5'b11100,5'b11011,5'b11010,5'b10111,5'b10110,
    5'b10011,5'b10010,5'b01111,5'b01110,5'b01011,5'b01010,5'b10101,5'b10100,5'b01001,5'b11110};

  // model: pos = 0 idle, 1 after J, 2 in data, 3 K with end pending, 4 after T, 5 after R
  int pos = 0;
  logic [4:0] exp_g = 5'b11111;
  string exp_tag = "R1";
  bit prev_r = 0;

  task automatic check_out();
    checks++;
    if (code_grp !== exp_g) begin
      errors++;
      $display("FAIL %s code_grp actual %b expected %b", exp_tag, code_grp, exp_g);
    end
    checks++;
    if (tx_active !== (exp_g != 5'b11111)) begin
      errors++;
      $display("FAIL R9 tx_active actual %b expected %b", tx_active, exp_g != 5'b11111);
    end
  endtask

  task automatic step(input logic en, input logic er, input logic [3:0] d);
    @(negedge clk);
    check_out();
    tx_en = en; tx_er = er; txd = d;
    if (pos == 0 || pos == 5) begin
      if (en) begin exp_g = 5'b11000; exp_tag = (pos == 5) ? "R8" : "R2"; pos = 1; end
      else begin exp_g = 5'b11111; exp_tag = "R7"; pos = 0; end
    end else if (pos == 1) begin
      exp_g = 5'b10001; exp_tag = "R3"; pos = en ? 2 : 3;
    end else if (pos == 2) begin
      if (!en) begin exp_g = 5'b01101; exp_tag = "R6"; pos = 4; end
      else if (er) begin exp_g = 5'b00100; exp_tag = "R5"; end
      else begin exp_g = TBL[5*d +: 5]; exp_tag = "R4"; end
    end else if (pos == 3) begin
      exp_g = 5'b01101; exp_tag = "R6"; pos = 4;
    end else begin
      exp_g = 5'b00111; exp_tag = "R6"; pos = 5;
    end
  endtask

  initial begin
    #(5 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_out();                       // R1 reset state
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) step(1'b0, k[0], 4'(k));   // R7 tx_er ignored while idle
    // R10-style edge: one-nibble frames first (R3 K still sent, R6 tail follows)
    for (int len = 1; len <= 20; len++) begin
      for (int gap = 1; gap <= 3; gap++) begin
        for (int i = 0; i < len; i++) begin
          logic er;
          er = (len % 3 == 0 && i == len / 2) || (i < 2 && gap == 2);
          step(1'b1, er, 4'((len * 3 + i * 5 + gap) % 16));
        end
        // gap 1 re-raises tx_en during T (R8); odd gaps drive tx_er while idle (R7)
        for (int g = 0; g < gap; g++) step(1'b0, gap[0], 4'(g + len));
      end
    end
    // every nibble value through the table (R4)
    for (int i = 0; i < 18; i++) step(1'b1, 1'b0, 4'((i + 14) % 16));
    for (int g = 0; g < 5; g++) step(1'b0, 1'b1, 4'hF);
    @(negedge clk);
    check_out();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule